// File: doc/BRIEF.md
# Sag Detector with Pre-Sag Hold

This block sits behind a symmetrical-component estimator in a series voltage compensator. Once per sample it receives the estimated positive-sequence and negative-sequence amplitude and phase, all in fixed point. It decides whether the supply is sagging by comparing the positive-sequence amplitude against the 1 pu nominal. While a sag lasts, it produces the reference parameters that downstream sine generation turns into the injected voltage.

Amplitude and phase reach the hold register and the one-cycle phase memory through a delay of Nd samples. Nd matches the detector's own latency, so the captured values come from before the disturbance and not from its first samples. A mode input selects the compensation strategy. The pre-sag strategy replays the stored phase cycle, which restores both amplitude and angle. The in-phase strategy keeps the live phase and restores only the amplitude.

The injected voltage is the sum of three phasors, and the block supplies the parameters of each:
- the reference, given by `refAmp` and `refPhase`;
- the live positive sequence turned by π, given by `liveAmp` and `oppPhase`;
- the live negative sequence turned by π, given by `cancelAmp` and `cancelPhase`.

The zero sequence is not used.

Top module: `sag_hold_ref`

## Requirements
- R1: While reset is asserted and after it is released, before any sample strobe, `sagFlag`, `outValid` and every reference output are zero.
- R2: A sample raises `sagFlag` from the output update of that same sample when `posAmp < 0x4000` and `0x4000 - posAmp` is strictly greater than `threshold`. An amplitude deficit equal to the threshold, or an amplitude above nominal, does not raise it. Amplitudes are unsigned with 1.0 pu = 0x4000.
- R3: On the detecting sample, `refAmp` takes the positive-sequence amplitude from Nd samples earlier, where Nd = floor(latency·fs) + 1. It keeps that value on every sample of the sag.
- R4: In pre-sag mode (`modeInPhase` = 0), `refPhase` during a sag replays the delayed phases stored over the last L = fs/f0 non-sag samples, oldest first, one per sample. It wraps back to the oldest entry after L samples. Phases are 16-bit two's-complement fractions of π.
- R5: In in-phase mode (`modeInPhase` = 1), `refPhase` during a sag equals the live `posPhase` of the same sample. The mode is taken per sample.
- R6: `sagFlag` clears on the 8th consecutive sample that does not meet the sag condition. Any sag sample inside that run restarts the count.
- R7: Outside a sag, `refAmp` and `refPhase` equal the live positive-sequence amplitude and phase, and `cancelAmp` is zero.
- R8: On every sample, `liveAmp` = `posAmp`, `oppPhase` = `posPhase` + 0x8000 and `cancelPhase` = `negPhase` + 0x8000, both modulo 2^16. During a sag, `cancelAmp` = `negAmp`.
- R9: Outputs change only on a clock edge where `sampleValid` is high. `outValid` is high for exactly the one cycle that follows such an edge.
- R10: After recovery, the delay line and the phase memory resume tracking. A later sag replays phases stored after the previous sag, and nothing stored during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | One-cycle strobe per estimator sample |
| posAmp | input | 16 | Positive-sequence amplitude, 1 pu = 0x4000 |
| posPhase | input | 16 | Positive-sequence phase, fraction of π |
| negAmp | input | 16 | Negative-sequence amplitude |
| negPhase | input | 16 | Negative-sequence phase |
| threshold | input | 16 | Sag depth threshold in amplitude units |
| modeInPhase | input | 1 | 1 = in-phase strategy, 0 = pre-sag strategy |
| sagFlag | output | 1 | Sag in progress |
| outValid | output | 1 | Outputs updated in the previous edge |
| refAmp | output | 16 | Reference amplitude |
| refPhase | output | 16 | Reference phase |
| liveAmp | output | 16 | Live positive amplitude to subtract |
| oppPhase | output | 16 | Live positive phase turned by π |
| cancelAmp | output | 16 | Negative-sequence cancel amplitude |
| cancelPhase | output | 16 | Negative-sequence phase turned by π |

## Verification
The bench builds the block with a 10 kHz sample rate, a 1 kHz fundamental and a 450 µs detector latency. The fundamental gives a 10-entry phase memory, and the latency gives a 5-sample delay. With a memory that short, the bench sees replay wrap many times inside one sag, and it sees several sags in a row reuse a memory that was refilled in between, within a few thousand samples. The 5-sample delay puts the captured amplitude clearly apart from the detecting sample, so a hold that grabbed a post-disturbance value is told apart from a correct one.

// File: rtl/sag_hold_pkg.sv
package sag_hold_pkg;

  // Strobes sent by the control to the datapath, one set per clock.
  typedef struct packed {
    logic shift;      // sample accepted: advance delay line, update outputs
    logic write;      // store delayed phase into the cycle memory
    logic capture;    // latch delayed amplitude into the hold register
    logic inSag;      // this sample is treated as part of a sag
    logic startPlay;  // first sample of replay: read from the write pointer
  } ctlStrobes_t;

  typedef enum logic {
    ST_TRACK = 1'b0,
    ST_SAG   = 1'b1
  } sagState_t;

endpackage

// File: rtl/sag_ctrl.sv
module sag_ctrl
  import sag_hold_pkg::*;
#(
  parameter int AMP_W     = 16,
  parameter int NOMINAL   = 16384,
  parameter int RECOV_CNT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [AMP_W-1:0] posAmp,
  input  logic [AMP_W-1:0] threshold,
  output ctlStrobes_t      ctl,
  output logic             sagFlag
);

  localparam int CNT_W = $clog2(RECOV_CNT + 1);

  sagState_t        state, stateNxt;
  logic [CNT_W-1:0] recCnt, recCntNxt;
  logic [AMP_W:0]   deficit;
  logic             sagCond;

  // Depth below nominal; only meaningful when the amplitude is below nominal.
  always_comb begin
    deficit = (AMP_W+1)'(NOMINAL) - {1'b0, posAmp};
    sagCond = (posAmp < AMP_W'(NOMINAL)) && (deficit > {1'b0, threshold});
  end

  always_comb begin
    stateNxt  = state;
    recCntNxt = recCnt;
    if (sampleValid) begin
      unique case (state)
        ST_TRACK: begin
          if (sagCond) begin
            stateNxt  = ST_SAG;
            recCntNxt = '0;
          end
        end
        ST_SAG: begin
          if (sagCond) begin
            recCntNxt = '0;
          end else if (recCnt == CNT_W'(RECOV_CNT - 1)) begin
            stateNxt  = ST_TRACK;
            recCntNxt = '0;
          end else begin
            recCntNxt = recCnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_TRACK;
      recCnt <= '0;
    end else begin
      state  <= stateNxt;
      recCnt <= recCntNxt;
    end
  end

  always_comb begin
    ctl.shift     = sampleValid;
    ctl.inSag     = (stateNxt == ST_SAG);
    ctl.write     = sampleValid && (stateNxt == ST_TRACK);
    ctl.capture   = sampleValid && (state == ST_TRACK) && (stateNxt == ST_SAG);
    ctl.startPlay = ctl.capture;
  end

  assign sagFlag = (state == ST_SAG);

endmodule

// File: rtl/sag_dpath.sv
module sag_dpath
  import sag_hold_pkg::*;
#(
  parameter int AMP_W     = 16,
  parameter int PH_W      = 16,
  parameter int DELAY_N   = 3,
  parameter int CYCLE_LEN = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      ctl,
  input  logic [AMP_W-1:0] posAmp,
  input  logic [PH_W-1:0]  posPhase,
  input  logic [AMP_W-1:0] negAmp,
  input  logic [PH_W-1:0]  negPhase,
  input  logic             modeInPhase,
  output logic             outValid,
  output logic [AMP_W-1:0] refAmp,
  output logic [PH_W-1:0]  refPhase,
  output logic [AMP_W-1:0] liveAmp,
  output logic [PH_W-1:0]  oppPhase,
  output logic [AMP_W-1:0] cancelAmp,
  output logic [PH_W-1:0]  cancelPhase
);

  localparam int PTR_W = (CYCLE_LEN > 1) ? $clog2(CYCLE_LEN) : 1;
  localparam logic [PH_W-1:0] HALF_TURN = {1'b1, {(PH_W-1){1'b0}}};

  // Sample delay line matched to the detector latency.
  logic [AMP_W-1:0] ampDly [DELAY_N];
  logic [PH_W-1:0]  phDly  [DELAY_N];

  for (genvar g = 0; g < DELAY_N; g++) begin : gDly
    if (g == 0) begin : gHead
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          ampDly[g] <= '0;
          phDly[g]  <= '0;
        end else if (ctl.shift) begin
          ampDly[g] <= posAmp;
          phDly[g]  <= posPhase;
        end
      end
    end else begin : gTail
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          ampDly[g] <= '0;
          phDly[g]  <= '0;
        end else if (ctl.shift) begin
          ampDly[g] <= ampDly[g-1];
          phDly[g]  <= phDly[g-1];
        end
      end
    end
  end

  logic [AMP_W-1:0] dlyAmp;
  logic [PH_W-1:0]  dlyPh;
  assign dlyAmp = ampDly[DELAY_N-1];
  assign dlyPh  = phDly[DELAY_N-1];

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(CYCLE_LEN - 1)) ? '0 : p + 1'b1;
  endfunction

  // One fundamental cycle of delayed phase samples.
  logic [PH_W-1:0]  phMem [CYCLE_LEN];
  logic [PTR_W-1:0] wrPtr, rdPtr, rdAddr;
  logic [AMP_W-1:0] holdAmp;

  assign rdAddr = ctl.startPlay ? wrPtr : rdPtr;

  always_ff @(posedge clk) begin
    if (ctl.write) phMem[wrPtr] <= dlyPh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      holdAmp <= '0;
    end else begin
      if (ctl.write)              wrPtr   <= stepPtr(wrPtr);
      if (ctl.shift && ctl.inSag) rdPtr   <= stepPtr(rdAddr);
      if (ctl.capture)            holdAmp <= dlyAmp;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      refAmp      <= '0;
      refPhase    <= '0;
      liveAmp     <= '0;
      oppPhase    <= '0;
      cancelAmp   <= '0;
      cancelPhase <= '0;
    end else begin
      outValid <= ctl.shift;
      if (ctl.shift) begin
        liveAmp     <= posAmp;
        oppPhase    <= posPhase + HALF_TURN;
        cancelPhase <= negPhase + HALF_TURN;
        if (ctl.inSag) begin
          refAmp    <= ctl.capture ? dlyAmp : holdAmp;
          refPhase  <= modeInPhase ? posPhase : phMem[rdAddr];
          cancelAmp <= negAmp;
        end else begin
          refAmp    <= posAmp;
          refPhase  <= posPhase;
          cancelAmp <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/sag_hold_ref.sv
module sag_hold_ref #(
  parameter int AMP_W          = 16,
  parameter int PH_W           = 16,
  parameter int NOMINAL        = 16384,
  parameter int SAMPLE_RATE_HZ = 10000,
  parameter int FUND_HZ        = 50,
  parameter int DET_LATENCY_US = 250,
  parameter int RECOV_CNT      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [AMP_W-1:0] posAmp,
  input  logic [PH_W-1:0]  posPhase,
  input  logic [AMP_W-1:0] negAmp,
  input  logic [PH_W-1:0]  negPhase,
  input  logic [AMP_W-1:0] threshold,
  input  logic             modeInPhase,
  output logic             sagFlag,
  output logic             outValid,
  output logic [AMP_W-1:0] refAmp,
  output logic [PH_W-1:0]  refPhase,
  output logic [AMP_W-1:0] liveAmp,
  output logic [PH_W-1:0]  oppPhase,
  output logic [AMP_W-1:0] cancelAmp,
  output logic [PH_W-1:0]  cancelPhase
);

  localparam int CYCLE_LEN = SAMPLE_RATE_HZ / FUND_HZ;
  localparam int DELAY_N   = (DET_LATENCY_US * SAMPLE_RATE_HZ) / 1000000 + 1;

  sag_hold_pkg::ctlStrobes_t ctl;

  sag_ctrl #(
    .AMP_W(AMP_W), .NOMINAL(NOMINAL), .RECOV_CNT(RECOV_CNT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .posAmp(posAmp), .threshold(threshold),
    .ctl(ctl), .sagFlag(sagFlag)
  );

  sag_dpath #(
    .AMP_W(AMP_W), .PH_W(PH_W), .DELAY_N(DELAY_N), .CYCLE_LEN(CYCLE_LEN)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .posAmp(posAmp), .posPhase(posPhase),
    .negAmp(negAmp), .negPhase(negPhase),
    .modeInPhase(modeInPhase),
    .outValid(outValid), .refAmp(refAmp), .refPhase(refPhase),
    .liveAmp(liveAmp), .oppPhase(oppPhase),
    .cancelAmp(cancelAmp), .cancelPhase(cancelPhase)
  );

endmodule

// File: rtl/sag_hold_chk.sv
module sag_hold_chk #(
  parameter int AMP_W   = 16,
  parameter int PH_W    = 16,
  parameter int NOMINAL = 16384
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleValid,
  input logic [AMP_W-1:0] posAmp,
  input logic [PH_W-1:0]  posPhase,
  input logic [AMP_W-1:0] threshold,
  input logic             modeInPhase,
  input logic             sagFlag,
  input logic             outValid,
  input logic [AMP_W-1:0] refAmp,
  input logic [PH_W-1:0]  refPhase,
  input logic [AMP_W-1:0] cancelAmp
);

  logic pastCond;
  assign pastCond = (int'(posAmp) < NOMINAL) &&
                    ((NOMINAL - int'(posAmp)) > int'(threshold));

  assert_rise_on_deficit_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sagFlag) |-> ($past(sampleValid) && $past(pastCond)));

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sagFlag && $past(sagFlag)) |-> $stable(refAmp));

  assert_inphase_live_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && sagFlag && $past(modeInPhase)) |-> (refPhase == $past(posPhase)));

  assert_fall_on_recovery_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sagFlag) |-> ($past(sampleValid) && !$past(pastCond)));

  assert_track_live_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !sagFlag) |-> (refAmp == $past(posAmp) && cancelAmp == '0));

  assert_flag_on_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sagFlag != $past(sagFlag)) |-> $past(sampleValid));

  assert_valid_follows_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(sampleValid));

endmodule

bind sag_hold_ref sag_hold_chk #(
  .AMP_W(AMP_W), .PH_W(PH_W), .NOMINAL(NOMINAL)
) u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
  .posAmp(posAmp), .posPhase(posPhase), .threshold(threshold),
  .modeInPhase(modeInPhase), .sagFlag(sagFlag), .outValid(outValid),
  .refAmp(refAmp), .refPhase(refPhase), .cancelAmp(cancelAmp)
);

// File: tb/tb_sag_hold_ref.sv
module tb_sag_hold_ref;

  localparam int FS    = 10000;
  localparam int F0    = 1000;
  localparam int LATUS = 450;
  localparam int L     = FS / F0;
  localparam int ND    = (LATUS * FS) / 1000000 + 1;
  localparam int RECOV = 8;
  localparam int NOM   = 16384;
  localparam int MAXN  = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [15:0] posAmp = '0, posPhase = '0, negAmp = '0, negPhase = '0, threshold = '0;
  logic modeInPhase = 1'b0;
  logic sagFlag, outValid;
  logic [15:0] refAmp, refPhase, liveAmp, oppPhase, cancelAmp, cancelPhase;

  always #4 clk = ~clk;

  sag_hold_ref #(
    .SAMPLE_RATE_HZ(FS), .FUND_HZ(F0), .DET_LATENCY_US(LATUS), .RECOV_CNT(RECOV)
  ) dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .posAmp(posAmp), .posPhase(posPhase), .negAmp(negAmp), .negPhase(negPhase),
    .threshold(threshold), .modeInPhase(modeInPhase),
    .sagFlag(sagFlag), .outValid(outValid), .refAmp(refAmp), .refPhase(refPhase),
    .liveAmp(liveAmp), .oppPhase(oppPhase), .cancelAmp(cancelAmp), .cancelPhase(cancelPhase)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Reference model state
  int inAmp [MAXN];
  int inPh  [MAXN];
  int hist  [MAXN];
  int nSmp = 0;
  int histLen = 0;
  bit mSag = 1'b0;
  int recc = 0;
  int mHold = 0;
  int playIdx = 0;
  int phAcc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic sendSample(input int amp, input int ph, input int namp,
                            input int nph, input bit mode, input int gap);
    int dAmp, dPh, expRA, expRP, expCA;
    bit cond;
    bit nxt;
    amp = amp & 16'hFFFF; ph = ph & 16'hFFFF;
    namp = namp & 16'hFFFF; nph = nph & 16'hFFFF;
    dAmp = (nSmp >= ND) ? inAmp[nSmp-ND] : 0;
    dPh  = (nSmp >= ND) ? inPh[nSmp-ND]  : 0;
    cond = (amp < NOM) && ((NOM - amp) > int'(threshold));
    nxt = mSag;
    if (!mSag) begin
      if (cond) begin
        nxt = 1'b1; recc = 0; mHold = dAmp; playIdx = 0;
      end
    end else begin
      if (cond) recc = 0;
      else if (recc == RECOV - 1) begin nxt = 1'b0; recc = 0; end
      else recc++;
    end
    expRP = ph;
    if (nxt) begin
      expRA = mHold;
      expCA = namp;
      if (!mode) expRP = hist[histLen - L + (playIdx % L)];
      playIdx++;
    end else begin
      expRA = amp; expCA = 0;
      hist[histLen] = dPh; histLen++;
    end
    inAmp[nSmp] = amp; inPh[nSmp] = ph; nSmp++;

    @(negedge clk);
    posAmp = 16'(amp); posPhase = 16'(ph); negAmp = 16'(namp); negPhase = 16'(nph);
    modeInPhase = mode; sampleValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sampleValid = 1'b0;
    chk(sagFlag == nxt, "R2 R6", "sagFlag", int'(sagFlag), int'(nxt));
    chk(outValid == 1'b1, "R9", "outValid", int'(outValid), 1);
    if (nxt) begin
      chk(int'(refAmp) == expRA, "R3", "refAmp held", int'(refAmp), expRA);
      if (mode) chk(int'(refPhase) == expRP, "R5", "refPhase live", int'(refPhase), expRP);
      else      chk(int'(refPhase) == expRP, "R4 R10", "refPhase replay", int'(refPhase), expRP);
    end else begin
      chk(int'(refAmp) == expRA, "R7", "refAmp track", int'(refAmp), expRA);
      chk(int'(refPhase) == expRP, "R7", "refPhase track", int'(refPhase), expRP);
    end
    chk(int'(cancelAmp) == expCA, "R8", "cancelAmp", int'(cancelAmp), expCA);
    chk(int'(liveAmp) == amp, "R8", "liveAmp", int'(liveAmp), amp);
    chk(int'(oppPhase) == ((ph + 32768) & 16'hFFFF), "R8", "oppPhase",
        int'(oppPhase), (ph + 32768) & 16'hFFFF);
    chk(int'(cancelPhase) == ((nph + 32768) & 16'hFFFF), "R8", "cancelPhase",
        int'(cancelPhase), (nph + 32768) & 16'hFFFF);
    mSag = nxt;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(outValid == 1'b0, "R9", "outValid idle", int'(outValid), 0);
      chk(int'(refAmp) == expRA, "R9", "refAmp idle", int'(refAmp), expRA);
    end
  endtask

  task automatic step(input int amp, input bit mode, input int gap);
    phAcc = (phAcc + 65536 / L + int'($urandom_range(0, 40))) & 16'hFFFF;
    sendSample(amp, phAcc, int'($urandom_range(0, 16'h0800)),
               int'($urandom_range(0, 16'hFFFF)), mode, gap);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog: actual=%0d expected=%0d", 200000, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seedInit;
    bit lowLevel;
    int amp;
    seedInit = $urandom(32'd715);
    threshold = 16'h0666;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sagFlag == 1'b0, "R1", "sagFlag in reset", int'(sagFlag), 0);
    chk(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    chk(refAmp == 16'h0, "R1", "refAmp in reset", int'(refAmp), 0);
    chk(cancelAmp == 16'h0, "R1", "cancelAmp in reset", int'(cancelAmp), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(sagFlag == 1'b0 && outValid == 1'b0, "R1", "after release",
        int'({sagFlag, outValid}), 0);
    chk(refPhase == 16'h0 && oppPhase == 16'h0, "R1", "phases after release",
        int'(refPhase), 0);

    // Warm-up: fill delay line and phase memory with healthy samples
    for (int i = 0; i < 4 * L; i++)
      step(NOM - 16'h0200 + int'($urandom_range(0, 16'h0400)), 1'($urandom_range(0, 1)), 0);

    // R2 boundaries: deficit equal to threshold, and a swell
    step(NOM - 16'h0666, 1'b0, 0);
    step(NOM + 16'h1000, 1'b0, 1);
    // R2/R3: one unit deeper starts the sag; replay wraps several times (R4)
    step(NOM - 16'h0667, 1'b0, 0);
    for (int i = 0; i < 3 * L; i++) step(16'h2000, 1'b0, 0);
    // R5: in-phase mode during the sag
    for (int i = 0; i < 4; i++) step(16'h2100, 1'b1, 0);
    // R6: partial recovery then a sag sample restarts the count
    for (int i = 0; i < 5; i++) step(16'h3F00, 1'b0, 0);
    step(16'h1000, 1'b0, 0);
    for (int i = 0; i < 7; i++) step(16'h3F00, 1'b0, 1);
    step(16'h3F80, 1'b0, 0);   // 8th recovering sample clears the flag
    // R10: track again, then a second sag replays newer history
    for (int i = 0; i < 2 * L; i++) step(NOM, 1'b0, 0);
    for (int i = 0; i < L + 3; i++) step(16'h0800, 1'b0, 0);
    for (int i = 0; i < RECOV; i++) step(NOM, 1'b0, 0);

    // Constrained random mix of levels, thresholds, modes and gaps
    lowLevel = 1'b0;
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 99) < 5) lowLevel = ~lowLevel;
      if ($urandom_range(0, 199) == 0) begin
        case ($urandom_range(0, 2))
          0: threshold = 16'h0333;
          1: threshold = 16'h0666;
          default: threshold = 16'h1000;
        endcase
      end
      if (lowLevel) amp = int'($urandom_range(16'h0800, 16'h3000));
      else          amp = int'($urandom_range(16'h3D00, 16'h4300));
      step(amp, 1'($urandom_range(0, 1)), int'($urandom_range(0, 2)));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule